// File: doc/BRIEF.md
# TDM Multichannel Slot Engine

This block frames a time-division-multiplexed serial link of the kind used for T1-style trunks. It has up to 128 fixed-width slots per frame. One system clock edge equals one bit clock. A frame sync marks the start of a frame, and a programmable delay of 0 to 15 bit clocks follows it before the first data bit. After that the engine walks through the slots bit by bit and shows the slot it is in on a current-slot output.

Two per-slot bitmaps choose the slots where the receiver captures a word and the slots where the transmitter drives one. Two more bitmaps flag the words that a downstream stage must compand. In an unselected slot the transmitter releases its pad: the output enable falls and the pad goes high-impedance. A transmit-data-valid strobe marks the selected slots. The engine can also make its own frame syncs, back to back, at the frame length set by the delay and slot count.

Top module: `tdm_slot_engine`

## Requirements
- R1: `slot_last` (7 bits) holds the number of slots minus one, so a frame has 1 to 128 slots, and `cur_slot` never exceeds `slot_last`.
- R2: With `frame_dly` = d (0..15), the first data bit falls d clocks after the clock in which the frame sync is active; with d = 0 it falls in the frame sync clock itself.
- R3: Each slot lasts WORD_BITS clocks, and all slots have the same length. During a data bit `cur_slot` shows the number of the slot being transferred; outside data bits it reads 0.
- R4: Bit n of `tx_map` enables transmit slot n, so the 32-bit word k of the map covers slots 32k..32k+31. `tx_oe` is high exactly during the bits of enabled transmit slots. At all other times the pad is released (high-impedance).
- R5: `tdv` is active exactly while `tx_oe` is high. With `tdv_pol` = 0 active means 1, and with `tdv_pol` = 1 active means 0.
- R6: `tx_word` is sampled in the first bit clock of an enabled transmit slot (`tx_load` pulses for that one clock) and is sent MSB first on `tx_d`.
- R7: After the last bit of a slot whose `rx_map` bit is set, `rx_valid` pulses for one clock on the next clock. During that pulse `rx_word` carries the word (first bit received is the MSB) and `rx_slot` carries the slot number. Slots whose `rx_map` bit is clear give no pulse.
- R8: `tx_cmp` equals `tx_cmp_map[cur_slot]` while transmitting, and `rx_cmp` equals `rx_cmp_map` for the captured slot during the `rx_valid` pulse.
- R9: With `fs_pol` = 1 the external frame sync `fs_in` is active low, and the internally made frame sync on `fs_out` is also active low.
- R10: With `fs_int_en` = 1 the engine ignores `fs_in` and makes a one-clock frame sync on `fs_out` whenever it is idle. The pulses are spaced d + (slot_last+1)·WORD_BITS clocks apart.
- R11: After the last bit of slot `slot_last`, the engine stays idle with no transmit, receive or slot activity until the next frame sync.
- R12: A frame sync that arrives in the middle of a frame restarts the delay count, and then slot 0, from that sync.
- R13: While `enable` is low, frame syncs are ignored and there is no transmit enable, valid strobe, load or receive pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Engine enable |
| fs_int_en | input | 1 | 1 = generate frame syncs internally |
| fs_pol | input | 1 | 1 = frame sync active low |
| tdv_pol | input | 1 | 1 = transmit-data-valid active low |
| slot_last | input | 7 | Number of slots minus one |
| frame_dly | input | 4 | Clocks from frame sync to first bit |
| tx_map | input | 128 | Transmit slot enables |
| rx_map | input | 128 | Receive slot enables |
| tx_cmp_map | input | 128 | Transmit compand flags |
| rx_cmp_map | input | 128 | Receive compand flags |
| fs_in | input | 1 | External frame sync |
| rx_d | input | 1 | Serial receive data |
| tx_word | input | 8 | Next word to transmit |
| fs_out | output | 1 | Internally generated frame sync |
| tx_d | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Transmit pad drive enable |
| tdv | output | 1 | Transmit data valid |
| tx_load | output | 1 | tx_word sampled this clock |
| tx_cmp | output | 1 | Current transmit word needs companding |
| cur_slot | output | 7 | Current slot number |
| rx_word | output | 8 | Captured receive word |
| rx_valid | output | 1 | rx_word valid pulse |
| rx_slot | output | 7 | Slot of captured word |
| rx_cmp | output | 1 | Captured word needs companding |

## Verification
The hardest situation to reach is a frame sync that lands partway through a slot, after a delay that is not zero. The restart must drop the partial word, run the delay count again and start slot 0 afresh, all without a spurious receive pulse or transmit load. The bench reaches it by firing a second sync a fixed number of clocks into a running frame and moving its expected-timeline origin to that clock. The delay corners (0, 1 and 15) and the full 128-slot frame come from the vector table, and every frame runs past its end so that the return to idle is checked too.

// File: rtl/tdm_slot_engine.sv
module tdm_slot_engine #(
  parameter int SLOTS     = 128,
  parameter int WORD_BITS = 8,
  parameter int DLY_W     = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic                     fs_int_en,
  input  logic                     fs_pol,
  input  logic                     tdv_pol,
  input  logic [$clog2(SLOTS)-1:0] slot_last,
  input  logic [DLY_W-1:0]         frame_dly,
  input  logic [SLOTS-1:0]         tx_map,
  input  logic [SLOTS-1:0]         rx_map,
  input  logic [SLOTS-1:0]         tx_cmp_map,
  input  logic [SLOTS-1:0]         rx_cmp_map,
  input  logic                     fs_in,
  input  logic                     rx_d,
  input  logic [WORD_BITS-1:0]     tx_word,
  output logic                     fs_out,
  output logic                     tx_d,
  output logic                     tx_oe,
  output logic                     tdv,
  output logic                     tx_load,
  output logic                     tx_cmp,
  output logic [$clog2(SLOTS)-1:0] cur_slot,
  output logic [WORD_BITS-1:0]     rx_word,
  output logic                     rx_valid,
  output logic [$clog2(SLOTS)-1:0] rx_slot,
  output logic                     rx_cmp
);
  localparam int SW = $clog2(SLOTS);
  localparam int BW = $clog2(WORD_BITS);

  typedef enum logic [1:0] {S_IDLE, S_DLY, S_RUN} st_t;

  st_t            st_r, st_n;
  logic [DLY_W-1:0] cnt_r, cnt_n;
  logic [BW-1:0]  bit_r, bit_n;
  logic [SW-1:0]  slot_r, slot_n;
  logic [WORD_BITS-1:0] tx_sh, rx_sh;

  logic int_fs, fs_hit, dly_zero, act;
  logic [BW-1:0] bit_now;
  logic [SW-1:0] slot_now;
  logic last_bit, last_slot, tx_sel, rx_sel;

  assign int_fs    = enable & fs_int_en & (st_r == S_IDLE);
  assign fs_hit    = enable & (fs_int_en ? int_fs : (fs_in ^ fs_pol));
  assign dly_zero  = (frame_dly == '0);
  assign act       = enable & (fs_hit ? dly_zero : (st_r == S_RUN));
  assign bit_now   = fs_hit ? '0 : bit_r;
  assign slot_now  = fs_hit ? '0 : slot_r;
  assign last_bit  = (bit_now == BW'(WORD_BITS - 1));
  assign last_slot = (slot_now == slot_last);

  always_comb begin
    st_n   = st_r;
    cnt_n  = cnt_r;
    bit_n  = bit_r;
    slot_n = slot_r;
    if (!enable) begin
      st_n = S_IDLE; cnt_n = '0; bit_n = '0; slot_n = '0;
    end else if (fs_hit && !dly_zero) begin
      bit_n = '0; slot_n = '0;
      if (frame_dly == DLY_W'(1)) begin
        st_n = S_RUN; cnt_n = '0;
      end else begin
        st_n = S_DLY; cnt_n = frame_dly - DLY_W'(2);
      end
    end else if (act) begin
      if (!last_bit) begin
        st_n = S_RUN; bit_n = bit_now + BW'(1); slot_n = slot_now;
      end else if (last_slot) begin
        st_n = S_IDLE; bit_n = '0; slot_n = '0;
      end else begin
        st_n = S_RUN; bit_n = '0; slot_n = slot_now + SW'(1);
      end
    end else if (st_r == S_DLY) begin
      if (cnt_r == '0) begin
        st_n = S_RUN; bit_n = '0; slot_n = '0;
      end else begin
        cnt_n = cnt_r - DLY_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_r <= S_IDLE; cnt_r <= '0; bit_r <= '0; slot_r <= '0;
    end else begin
      st_r <= st_n; cnt_r <= cnt_n; bit_r <= bit_n; slot_r <= slot_n;
    end
  end

  assign tx_sel   = act & tx_map[slot_now];
  assign rx_sel   = act & rx_map[slot_now];
  assign tx_oe    = tx_sel;
  assign tdv      = tx_sel ^ tdv_pol;
  assign tx_load  = tx_sel & (bit_now == '0);
  assign tx_cmp   = tx_sel & tx_cmp_map[slot_now];
  assign tx_d     = tx_sel & (tx_load ? tx_word[WORD_BITS-1] : tx_sh[WORD_BITS-1]);
  assign cur_slot = act ? slot_now : '0;
  assign fs_out   = int_fs ^ fs_pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_sh <= '0;
    else if (tx_load) tx_sh <= tx_word << 1;
    else if (tx_sel) tx_sh <= tx_sh << 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh <= '0; rx_word <= '0; rx_valid <= 1'b0; rx_slot <= '0; rx_cmp <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (rx_sel) begin
        rx_sh <= {rx_sh[WORD_BITS-2:0], rx_d};
        if (last_bit) begin
          rx_word  <= {rx_sh[WORD_BITS-2:0], rx_d};
          rx_valid <= 1'b1;
          rx_slot  <= slot_now;
          rx_cmp   <= rx_cmp_map[slot_now];
        end
      end
    end
  end
endmodule

// File: rtl/tdm_slot_engine_chk.sv
module tdm_slot_engine_chk #(
  parameter int SLOTS = 128
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     enable,
  input logic                     tdv_pol,
  input logic [$clog2(SLOTS)-1:0] slot_last,
  input logic [SLOTS-1:0]         tx_map,
  input logic                     tx_oe,
  input logic                     tdv,
  input logic                     tx_load,
  input logic                     rx_valid,
  input logic [$clog2(SLOTS)-1:0] cur_slot
);
  a_r1_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cur_slot <= slot_last);
  a_r4_oe_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    tx_oe |-> tx_map[cur_slot]);
  a_r5_tdv_marks_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (tdv ^ tdv_pol) == tx_oe);
  a_r6_load_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> !tx_load);
  a_r7_rx_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  a_r13_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!tx_oe && !tx_load));
endmodule

bind tdm_slot_engine tdm_slot_engine_chk #(.SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .tdv_pol(tdv_pol),
  .slot_last(slot_last), .tx_map(tx_map), .tx_oe(tx_oe), .tdv(tdv),
  .tx_load(tx_load), .rx_valid(rx_valid), .cur_slot(cur_slot));

// File: tb/sim_tdm_slot_engine.sv
module sim_tdm_slot_engine;
  localparam int W = 8;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, fs_int_en = 1'b0;
  logic fs_pol = 1'b0, tdv_pol = 1'b0;
  logic [6:0] slot_last = '0;
  logic [3:0] frame_dly = '0;
  logic [127:0] tx_map = '0, rx_map = '0, tx_cmp_map = '0, rx_cmp_map = '0;
  logic fs_in = 1'b0, rx_d = 1'b0;
  logic [W-1:0] tx_word = '0;
  logic fs_out, tx_d, tx_oe, tdv, tx_load, tx_cmp, rx_valid, rx_cmp;
  logic [6:0] cur_slot, rx_slot;
  logic [W-1:0] rx_word;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  tdm_slot_engine u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .fs_int_en(fs_int_en),
    .fs_pol(fs_pol), .tdv_pol(tdv_pol), .slot_last(slot_last),
    .frame_dly(frame_dly), .tx_map(tx_map), .rx_map(rx_map),
    .tx_cmp_map(tx_cmp_map), .rx_cmp_map(rx_cmp_map), .fs_in(fs_in),
    .rx_d(rx_d), .tx_word(tx_word), .fs_out(fs_out), .tx_d(tx_d),
    .tx_oe(tx_oe), .tdv(tdv), .tx_load(tx_load), .tx_cmp(tx_cmp),
    .cur_slot(cur_slot), .rx_word(rx_word), .rx_valid(rx_valid),
    .rx_slot(rx_slot), .rx_cmp(rx_cmp));

  // {slot_last, delay, tx pattern, rx pattern, compand pattern}
  localparam logic [106:0] VEC [6] = '{
    {7'd3,   4'd0,  32'h0000_000D, 32'h0000_000B, 32'h0000_0005},
    {7'd0,   4'd1,  32'h0000_0001, 32'h0000_0001, 32'h0000_0001},
    {7'd5,   4'd15, 32'h0000_002A, 32'h0000_0015, 32'h0000_003C},
    {7'd127, 4'd2,  32'h8000_0001, 32'h4000_0003, 32'hF0F0_0F0F},
    {7'd2,   4'd3,  32'h0000_0000, 32'h0000_0007, 32'h0000_0002},
    {7'd7,   4'd0,  32'h0000_00FF, 32'h0000_0000, 32'h0000_00AA}
  };

  function automatic logic [W-1:0] txw(int s);
    return W'(8'h5A ^ (s * 3));
  endfunction
  function automatic logic [W-1:0] rxw(int s);
    return W'(8'hC3 + s * 7);
  endfunction

  task automatic chk(bit ok, string tag, logic [127:0] a, logic [127:0] e);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, a, e, $time);
    end
  endtask

  task automatic run_frame(int nch, int d, logic [31:0] tp, logic [31:0] rp,
                           logic [31:0] cp, int restart, bit fpol, bit tpol,
                           string pfx);
    int base = 0;
    int lf = d + (nch + 1) * W;
    bit pv = 0;
    logic [W-1:0] pw = '0;
    int ps = 0;
    bit pc = 0;
    logic [127:0] txm = {~tp, tp, ~tp, tp};
    logic [127:0] rxm = {rp, ~rp, rp, ~rp};
    logic [127:0] tcm = {4{cp}};
    logic [127:0] rcm = {4{~cp}};
    @(negedge clk);
    slot_last = 7'(nch); frame_dly = 4'(d); tx_map = txm; rx_map = rxm;
    tx_cmp_map = tcm; rx_cmp_map = rcm; fs_pol = fpol; tdv_pol = tpol;
    fs_int_en = 1'b0; enable = 1'b1; fs_in = fpol;
    for (int k = 0; k < lf + W + 3 + (restart > 0 ? restart : 0); k++) begin
      bit a, eo, fire;
      int kk, sl, b;
      @(negedge clk);
      fire = (k == 0) || (k == restart);
      if (k == restart) base = k;
      kk = k - base;
      a  = (kk >= d) && (kk < lf);
      sl = a ? (kk - d) / W : 0;
      b  = a ? (kk - d) % W : 0;
      fs_in   = fire ^ fpol;
      tx_word = txw(sl);
      rx_d    = a ? rxw(sl)[W-1-b] : 1'b0;
      eo = a && txm[sl];
      #1;
      chk(tx_oe === eo, {pfx, a ? "R4 tx_oe" : (kk >= lf ? "R11 tx_oe idle" : "R2 tx_oe before first bit")}, 128'(tx_oe), 128'(eo));
      chk(tdv === (eo ^ tpol), {pfx, "R5 tdv"}, 128'(tdv), 128'(eo ^ tpol));
      chk(cur_slot === 7'(sl), {pfx, "R1/R3 cur_slot"}, 128'(cur_slot), 128'(sl));
      chk(tx_load === (eo && b == 0), {pfx, "R6 tx_load"}, 128'(tx_load), 128'(eo && b == 0));
      if (eo) begin
        chk(tx_d === txw(sl)[W-1-b], {pfx, "R6 tx_d"}, 128'(tx_d), 128'(txw(sl)[W-1-b]));
        chk(tx_cmp === tcm[sl], {pfx, "R8 tx_cmp"}, 128'(tx_cmp), 128'(tcm[sl]));
      end
      chk(rx_valid === pv, {pfx, "R7 rx_valid"}, 128'(rx_valid), 128'(pv));
      if (pv) begin
        chk(rx_word === pw, {pfx, "R7 rx_word"}, 128'(rx_word), 128'(pw));
        chk(rx_slot === 7'(ps), {pfx, "R7 rx_slot"}, 128'(rx_slot), 128'(ps));
        chk(rx_cmp === pc, {pfx, "R8 rx_cmp"}, 128'(rx_cmp), 128'(pc));
      end
      pv = a && rxm[sl] && (b == W - 1);
      pw = rxw(sl); ps = sl; pc = rcm[sl];
    end
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(tx_oe === 1'b0 && rx_valid === 1'b0 && tx_load === 1'b0, "R13 reset outputs quiet",
        128'({tx_oe, rx_valid, tx_load}), 128'(0));
    chk(cur_slot === 7'd0, "R3 reset cur_slot", 128'(cur_slot), 128'(0));
    chk(tdv === 1'b0, "R5 reset tdv", 128'(tdv), 128'(0));

    for (int v = 0; v < 6; v++)
      run_frame(int'(VEC[v][106:100]), int'(VEC[v][99:96]), VEC[v][95:64],
                VEC[v][63:32], VEC[v][31:0], -1, 1'b0, 1'b0, "");

    run_frame(3, 2, 32'h0000_000F, 32'h0000_000F, 32'h0000_0009, 13, 1'b0, 1'b0, "R12 ");
    run_frame(3, 0, 32'h0000_0005, 32'h0000_000A, 32'h0000_0003, 9, 1'b0, 1'b0, "R12 ");
    run_frame(2, 1, 32'h0000_0005, 32'h0000_0006, 32'h0000_0001, -1, 1'b1, 1'b1, "R9 ");

    @(negedge clk);
    enable = 1'b0; fs_pol = 1'b0; tdv_pol = 1'b0;
    tx_map = '1; rx_map = '1; slot_last = 7'd1; frame_dly = 4'd0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      fs_in = (k % 5 == 0); rx_d = k[0];
      #1;
      chk({tx_oe, tdv, tx_load, rx_valid} === 4'b0, "R13 disabled activity",
          128'({tx_oe, tdv, tx_load, rx_valid}), 128'(0));
      chk(cur_slot === 7'd0, "R13 disabled cur_slot", 128'(cur_slot), 128'(0));
    end

    begin
      int first = -1, second = -1, third = -1;
      @(negedge clk);
      fs_in = 1'b0; tx_map = '0; rx_map = '0;
      slot_last = 7'd1; frame_dly = 4'd3; fs_int_en = 1'b1; enable = 1'b1;
      for (int k = 0; k < 80; k++) begin
        @(negedge clk);
        fs_in = k[0];
        #1;
        if (fs_out === 1'b1) begin
          if (first < 0) first = k;
          else if (second < 0) second = k;
          else if (third < 0) third = k;
        end
      end
      chk(second - first == 19, "R10 internal sync period", 128'(second - first), 128'(19));
      chk(third - second == 19, "R10 internal sync period repeat", 128'(third - second), 128'(19));
      @(negedge clk);
      enable = 1'b0; fs_int_en = 1'b0;
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule